// File: doc/BRIEF.md
# Staged Frequency Word Register

This block assembles a wide frequency word from a series of narrow byte writes. Each write targets one lane of the word by a lane index. The writes land in a staging bank, and the visible word does not move until the most significant lane has been written as the last step of an unbroken ascending run that starts at lane 0. All lanes then reach the output together on a single clock edge, and an update strobe marks that edge. Whatever consumes the word, such as a phase accumulator, therefore never sees a mix of old and new bytes.

An arming flag guards the bank. A power-on indication clears the flag, and only the synchronous reset sets it. Until the reset has been applied at least once after power-on, every write is dropped. A separate read index returns any staged lane, and reading has no effect on the committed word.

Top module: `freq_word_stage`

## Requirements
- R1: Lane k of the word occupies bits [8k+7:8k]. Lane 0 is the least significant byte and lane 3 the most significant.
- R2: A commit happens on a write to lane 3 that directly follows accepted writes to lanes 0, 1 and 2 in that order. After the clock edge that samples this write, `freq_word` holds all four new lanes together.
- R3: `freq_word` keeps its value through any incomplete or broken sequence. It changes only on a commit (R2), a reset (R8) or a power-on (R10).
- R4: `upd_pulse` is high for exactly one cycle, the first cycle in which a newly committed value is visible. It is low at all other times.
- R5: A write to a lane index that is neither 0 nor the expected next lane is dropped. It leaves every staged lane unchanged, and the sequence then expects lane 0 again.
- R6: A write to lane 0 is always accepted, even in the middle of a sequence. It restarts the sequence, so that lane 1 is expected next.
- R7: While the arming flag is clear, all writes are dropped. The staged lanes and `freq_word` stay as they are, and no pulse occurs.
- R8: A cycle with `rst` high sets the arming flag. It clears the staged lanes, the sequence position and `freq_word` to zero, and it raises no pulse. When `por` and `rst` are high together, `por` wins and the flag stays clear.
- R9: `rd_data` shows the staged lane selected by `rd_idx` in the same cycle, and reading does not disturb `freq_word`.
- R10: After `por`, `freq_word`, all staged lanes and `upd_pulse` are zero, and the arming flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on indication, synchronous, active high; clears everything and disarms |
| rst | input | 1 | Synchronous reset, active high; clears the state and arms the block |
| wr_en | input | 1 | Byte write strobe |
| wr_idx | input | 2 | Lane index of the write |
| wr_data | input | 8 | Byte being written |
| rd_idx | input | 2 | Lane index for readback |
| rd_data | output | 8 | Staged byte at `rd_idx` |
| freq_word | output | 32 | Committed frequency word |
| upd_pulse | output | 1 | One-cycle strobe when `freq_word` takes a new committed value |

## Verification
The bench writes a clean ascending run of four lanes, which shows both the byte placement and the single commit. A run that stops after two lanes shows that the staged bytes can be read back while the output holds. Writes to lane 3 or lane 2 out of turn separate dropping a byte from accepting it, and a lane-0 write in the middle of a run, followed by a complete run, separates a restart from a plain drop. Writes made before any reset, writes made after `por` together with `rst`, and a reset in the middle of a sequence show that the arming flag gates the bank and that a reset discards partial progress.

// File: rtl/fws_pkg.sv
package fws_pkg;
    localparam int unsigned FWS_LANES  = 4;
    localparam int unsigned FWS_LANE_W = 8;

    typedef struct packed {
        logic armed;
    } arm_state_t;
endpackage

// File: rtl/fws_arm_flag.sv
module fws_arm_flag (
    input  logic clk,
    input  logic por,
    input  logic rst,
    output logic armed
);
    import fws_pkg::*;

    arm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por) begin
            st_d.armed = 1'b0;          // power-on always disarms, even with rst high
        end else if (rst) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign armed = st_q.armed;
endmodule

// File: rtl/fws_seq_track.sv
module fws_seq_track #(
    parameter int unsigned LANES = fws_pkg::FWS_LANES,
    localparam int unsigned IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             armed,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [LANES-1:0] lane_we,
    output logic             last_hit
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);
    localparam logic [IDX_W-1:0] FIRST_NEXT = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       take;

    always_comb begin
        st_d     = st_q;
        take     = 1'b0;
        last_hit = 1'b0;
        if (clr) begin
            st_d.ptr = '0;
        end else if (armed && wr_en) begin
            if (wr_idx == '0) begin
                take     = 1'b1;             // lane 0 always restarts the run
                st_d.ptr = FIRST_NEXT;
            end else if (wr_idx == st_q.ptr) begin
                take = 1'b1;
                if (wr_idx == LAST_IDX) begin
                    last_hit = 1'b1;
                    st_d.ptr = '0;
                end else begin
                    st_d.ptr = st_q.ptr + FIRST_NEXT;
                end
            end else begin
                st_d.ptr = '0;               // out of order: drop and rewind
            end
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lane_we[k] = take && (wr_idx == IDX_W'(k));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/fws_lane_bank.sv
module fws_lane_bank #(
    parameter int unsigned LANES  = fws_pkg::FWS_LANES,
    parameter int unsigned LANE_W = fws_pkg::FWS_LANE_W,
    localparam int unsigned IDX_W  = $clog2(LANES),
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [LANES-1:0]  lane_we,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LANE_W-1:0] rd_data,
    output logic [WORD_W-1:0] staged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (clr) begin
                lane_d = '0;
            end else if (lane_we[g]) begin
                lane_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            lane_q <= lane_d;
        end

        assign staged[g*LANE_W +: LANE_W] = lane_q;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < LANES; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_data = staged[k*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/freq_word_stage.sv
module freq_word_stage #(
    parameter int unsigned LANES  = fws_pkg::FWS_LANES,
    parameter int unsigned LANE_W = fws_pkg::FWS_LANE_W,
    localparam int unsigned IDX_W  = $clog2(LANES),
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LANE_W-1:0] rd_data,
    output logic [WORD_W-1:0] freq_word,
    output logic              upd_pulse
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              upd;
    } out_state_t;

    logic              armed;
    logic              clr;
    logic [LANES-1:0]  lane_we;
    logic              last_hit;
    logic [WORD_W-1:0] staged;
    out_state_t        out_d, out_q;

    assign clr = por || rst;

    fws_arm_flag u_arm (
        .clk   (clk),
        .por   (por),
        .rst   (rst),
        .armed (armed)
    );

    fws_seq_track #(.LANES(LANES)) u_seq (
        .clk      (clk),
        .clr      (clr),
        .armed    (armed),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .lane_we  (lane_we),
        .last_hit (last_hit)
    );

    fws_lane_bank #(.LANES(LANES), .LANE_W(LANE_W)) u_bank (
        .clk     (clk),
        .clr     (clr),
        .lane_we (lane_we),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .staged  (staged)
    );

    // The top lane is written on the same edge as the commit, so it is
    // taken from the write data rather than from the staging bank.
    always_comb begin
        out_d     = out_q;
        out_d.upd = 1'b0;
        if (clr) begin
            out_d.word = '0;
        end else if (last_hit) begin
            out_d.word = staged;
            out_d.word[WORD_W-1 -: LANE_W] = wr_data;
            out_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign freq_word = out_q.word;
    assign upd_pulse = out_q.upd;
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
    parameter int unsigned LANES  = fws_pkg::FWS_LANES,
    parameter int unsigned LANE_W = fws_pkg::FWS_LANE_W,
    localparam int unsigned IDX_W  = $clog2(LANES),
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input logic              clk,
    input logic              por,
    input logic              rst,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [LANE_W-1:0] wr_data,
    input logic              armed,
    input logic [WORD_W-1:0] freq_word,
    input logic              upd_pulse
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    logic pv_q = 1'b0;
    always_ff @(posedge clk) begin
        pv_q <= 1'b1;
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (por)
        (pv_q && upd_pulse) |=> !upd_pulse);

    a_r2_commit_on_last: assert property (@(posedge clk) disable iff (por)
        (pv_q && upd_pulse) |-> $past(wr_en && armed && (wr_idx == LAST_IDX)));

    a_r1_top_lane: assert property (@(posedge clk) disable iff (por)
        (pv_q && upd_pulse) |-> (freq_word[WORD_W-1 -: LANE_W] == $past(wr_data)));

    a_r3_hold_word: assert property (@(posedge clk) disable iff (por)
        (pv_q && !upd_pulse && !$past(rst) && !$past(por)) |-> $stable(freq_word));

    a_r8_rst_clears: assert property (@(posedge clk) disable iff (por)
        (pv_q && $past(rst)) |-> ((freq_word == '0) && !upd_pulse));

    a_r7_unarmed_no_commit: assert property (@(posedge clk) disable iff (por)
        (pv_q && !$past(armed)) |-> !upd_pulse);
endmodule

bind freq_word_stage fws_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .por       (por),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .armed     (armed),
    .freq_word (freq_word),
    .upd_pulse (upd_pulse)
);

// File: tb/sim_freq_word_stage.sv
module sim_freq_word_stage;
    logic        clk = 1'b0;
    logic        por = 1'b0;
    logic        rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic [31:0] freq_word;
    logic        upd_pulse;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];

    bit          m_armed = 1'b0;
    int          m_ptr = 0;
    logic [7:0]  m_st[4];
    logic [31:0] m_word = '0;

    always #2 clk = ~clk;

    freq_word_stage u0 (
        .clk       (clk),
        .por       (por),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .freq_word (freq_word),
        .upd_pulse (upd_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every pulse must match the next queued expected word (R4, R2)
    always @(negedge clk) begin
        if (!done && upd_pulse) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected pulse", freq_word, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(freq_word == e, "R2 committed word at pulse", freq_word, e);
            end
        end
    end

    task automatic model_clear();
        m_ptr = 0;
        m_word = '0;
        for (int k = 0; k < 4; k++) m_st[k] = '0;
    endtask

    task automatic wr(input int idx, input logic [7:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1;
        wr_idx = idx[1:0];
        wr_data = d;
        if (m_armed) begin
            if (idx == 0) begin
                m_st[0] = d;
                m_ptr = 1;
            end else if (idx == m_ptr) begin
                m_st[idx] = d;
                if (idx == 3) begin
                    m_word = {m_st[3], m_st[2], m_st[1], m_st[0]};
                    exp_q.push_back(m_word);
                    m_ptr = 0;
                end else begin
                    m_ptr = m_ptr + 1;
                end
            end else begin
                m_ptr = 0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(freq_word == m_word, req, freq_word, m_word);
    endtask

    task automatic rd(input int idx, input string req);
        @(negedge clk);
        rd_idx = idx[1:0];
        #1;
        chk(rd_data == m_st[idx], req, {24'h0, rd_data}, {24'h0, m_st[idx]});
        chk(freq_word == m_word, "R9 readback leaves word", freq_word, m_word);
    endtask

    task automatic pulse_ctl(input bit p, input bit r);
        @(negedge clk);
        por = p;
        rst = r;
        @(negedge clk);
        por = 1'b0;
        rst = 1'b0;
        if (p) begin
            m_armed = 1'b0;
            model_clear();
        end else if (r) begin
            m_armed = 1'b1;
            model_clear();
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        model_clear();
        // R10: power-on state
        pulse_ctl(1'b1, 1'b0);
        chk(freq_word == 32'h0, "R10 word after power-on", freq_word, 32'h0);
        chk(upd_pulse == 1'b0, "R10 pulse after power-on", {31'h0, upd_pulse}, 32'h0);
        for (int k = 0; k < 4; k++) rd(k, "R10 staged lane after power-on");

        // R7: not yet armed, a full run is dropped
        wr(0, 8'h9a, "R7 unarmed write lane 0");
        wr(1, 8'h9b, "R7 unarmed write lane 1");
        wr(2, 8'h9c, "R7 unarmed write lane 2");
        wr(3, 8'h9d, "R7 unarmed write lane 3");
        rd(0, "R7 unarmed staging untouched");
        rd(3, "R7 unarmed staging untouched");

        // R8: reset arms the block
        pulse_ctl(1'b0, 1'b1);
        chk(freq_word == 32'h0, "R8 word after reset", freq_word, 32'h0);

        // R1 R2 R3: clean ascending run
        wr(0, 8'h11, "R3 hold after lane 0");
        wr(1, 8'h22, "R3 hold after lane 1");
        wr(2, 8'h33, "R3 hold after lane 2");
        wr(3, 8'h44, "R1 lane placement on commit");
        chk(freq_word == 32'h44332211, "R1 byte order", freq_word, 32'h44332211);
        @(negedge clk);
        chk(upd_pulse == 1'b0, "R4 pulse lasts one cycle", {31'h0, upd_pulse}, 32'h0);

        // R9 R3: partial run, readback
        wr(0, 8'haa, "R3 partial lane 0");
        wr(1, 8'hbb, "R3 partial lane 1");
        rd(0, "R9 readback lane 0");
        rd(1, "R9 readback lane 1");
        rd(2, "R9 readback lane 2");

        // R5: out-of-order writes dropped
        wr(3, 8'hcc, "R5 out-of-order lane 3");
        rd(3, "R5 lane 3 unchanged after drop");
        wr(2, 8'hdd, "R5 lane 2 after rewind");
        rd(2, "R5 lane 2 unchanged after drop");

        // R6: lane 0 mid-run restarts
        wr(0, 8'h01, "R6 first lane 0");
        wr(1, 8'h02, "R6 first lane 1");
        wr(0, 8'h05, "R6 restart lane 0");
        wr(1, 8'h06, "R6 lane 1");
        wr(2, 8'h07, "R6 lane 2");
        wr(3, 8'h08, "R6 commit after restart");
        chk(freq_word == 32'h08070605, "R6 restarted word", freq_word, 32'h08070605);

        // R8: reset mid-run discards progress
        wr(0, 8'h51, "R8 pre-reset lane 0");
        wr(1, 8'h52, "R8 pre-reset lane 1");
        pulse_ctl(1'b0, 1'b1);
        chk(freq_word == 32'h0, "R8 word cleared by reset", freq_word, 32'h0);
        rd(0, "R8 staging cleared by reset");
        wr(2, 8'h53, "R8 lane 2 after reset dropped");
        wr(3, 8'h54, "R8 lane 3 after reset dropped");

        // R8 R7: power-on and reset together leave the block disarmed
        pulse_ctl(1'b1, 1'b1);
        wr(0, 8'h61, "R8 por priority lane 0");
        wr(1, 8'h62, "R8 por priority lane 1");
        wr(2, 8'h63, "R8 por priority lane 2");
        wr(3, 8'h64, "R7 por priority lane 3");
        rd(0, "R7 staging untouched while disarmed");

        // re-arm and commit once more
        pulse_ctl(1'b0, 1'b1);
        wr(0, 8'hf0, "R2 lane 0");
        wr(1, 8'he1, "R2 lane 1");
        wr(2, 8'hd2, "R2 lane 2");
        wr(3, 8'hc3, "R2 final commit");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 every commit pulsed", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule